// File: doc/BRIEF.md
# Instruction Cache Autoload Prefetcher

This block decides which instruction-cache lines to fetch ahead of the processor. It watches each lookup result from the cache: whether the lookup hit, and which address it used. When the trigger mode selects that kind of result and the address lies in one of two enabled address windows, the block asks for the next few lines. It stops at the window's edge. It sends one line-aligned request at a time on a valid/ready port. It waits for a fill-done pulse before it moves on to the next line.

Software can also start a manual preload of an address range. The start saves the current autoload enable, turns autoload off and reports the saved value. A done flag reads 0 until the last line of the range has been filled. An end pulse puts the saved enable back. While the cache is frozen the block holds its pending request and does not present it. The cache arrays, the tag lookup and the external fetch are outside this block.

The controller has five named states:
- `PF_IDLE` watches lookups and pending manual starts.
- `PF_AUTO_REQ` and `PF_AUTO_WAIT` present an autoload line and then wait for its fill.
- `PF_MAN_REQ` and `PF_MAN_WAIT` do the same for a manual preload.

The transitions are:
- Idle → man-req when a manual preload is pending and its line count is not zero. A pending preload with a line count of zero stays in idle.
- Idle → auto-req on a qualifying lookup.
- Req → wait when the request is accepted.
- Wait → req on fill done when lines remain and the next step is in bounds.
- Wait → idle on fill done otherwise. An autoload burst also returns to idle on fill done when autoload has been switched off.

Top module: `icache_prefetch_engine`

## Requirements
- R1: Every request address has its low log2(LINE_BYTES) bits at zero. After a request is accepted (req_valid and req_ready), req_valid stays 0 until a fill_done pulse arrives. While req_valid is 1 and not accepted, req_addr stays unchanged.
- R2: cfg_trigger selects which lookups start autoload: 0 = misses only, 1 = hits only, 2 = both, 3 = none. Autoload starts only while the autoload enable (auto_on) is 1. That enable is written by cfg_auto_we/cfg_auto_wdata and is 0 after reset.
- R3: A lookup qualifies only if its address lies in an enabled window, with base ≤ addr < base+size. Window 0 takes precedence over window 1 when both contain the address, and its bounds are the ones used.
- R4: A qualifying lookup requests up to AUTO_LINES lines after the line that holds the address. cfg_order 0 steps the address up by LINE_BYTES, and 1 steps it down.
- R5: Autoload stops before the first line whose start address would fall outside the window. A downward step never wraps below address 0.
- R6: An accepted manual start (man_start while man_done is 1) has these effects from the next cycle: auto_on = 0, man_done = 0, and man_prev_auto = the enable value before the start. If a qualifying lookup arrives in the same cycle as the start, it is dropped.
- R7: A manual preload requests ceil(man_size/LINE_BYTES) lines, limited to CACHE_BYTES/LINE_BYTES lines. It starts at the line that holds man_addr and steps up (man_order 0) or down (man_order 1). It stops early rather than wrap past either end of the address space.
- R8: man_done is 1 after reset. It is 0 in the cycle after an accepted start. It returns to 1 in the cycle after the last fill_done. For a size of 0 it returns to 1 one cycle after it dropped.
- R9: A man_end pulse restores auto_on to the value saved by the last accepted start.
- R10: While freeze is 1, req_valid is 0. A request held back this way is presented once freeze drops.
- R11: Lookups are ignored while a preload or a burst is in progress. A man_start is ignored while man_done is 0.
- R12: After reset, req_valid = 0, man_done = 1, auto_on = 0 and man_prev_auto = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_order | input | 1 | Autoload step direction (0 up, 1 down) |
| cfg_trigger | input | 2 | Autoload trigger source |
| cfg_auto_we | input | 1 | Write strobe for the autoload enable |
| cfg_auto_wdata | input | 1 | Value for the autoload enable |
| rgn0_en | input | 1 | Window 0 enable |
| rgn0_base | input | AW | Window 0 start address |
| rgn0_size | input | AW | Window 0 size in bytes |
| rgn1_en | input | 1 | Window 1 enable |
| rgn1_base | input | AW | Window 1 start address |
| rgn1_size | input | AW | Window 1 size in bytes |
| lookup_valid | input | 1 | Cache lookup result valid |
| lookup_hit | input | 1 | Lookup was a hit |
| lookup_addr | input | AW | Lookup address |
| freeze | input | 1 | Cache frozen: present no request |
| man_start | input | 1 | Start a manual preload |
| man_addr | input | AW | Manual preload start address |
| man_size | input | AW | Manual preload size in bytes |
| man_order | input | 1 | Manual step direction (0 up, 1 down) |
| man_end | input | 1 | End the manual preload and restore the enable |
| man_done | output | 1 | 1 when no manual preload is running |
| man_prev_auto | output | 1 | Autoload enable saved at the last start |
| auto_on | output | 1 | Current autoload enable |
| req_valid | output | 1 | Line request valid |
| req_ready | input | 1 | Line request accepted |
| req_addr | output | AW | Line-aligned request address |
| fill_done | input | 1 | Fill of the outstanding line finished |

## Verification
Two events can fall in the same cycle: a manual start and a lookup that would trigger autoload. The bench drives both on the same clock edge with autoload enabled. It then expects exactly the manual line sequence, a saved enable of 1 and auto_on at 0, and no autoload line. A second collision is a freeze raised over a request that is already pending. The bench checks that req_valid stays 0 for the whole frozen interval and that the same line list then appears unchanged once freeze drops.

// File: rtl/icpf_pkg.sv
package icpf_pkg;

    typedef enum logic [2:0] {
        PF_IDLE,
        PF_AUTO_REQ,
        PF_AUTO_WAIT,
        PF_MAN_REQ,
        PF_MAN_WAIT
    } pf_state_e;

    localparam logic [1:0] TRIG_MISS = 2'd0;
    localparam logic [1:0] TRIG_HIT  = 2'd1;
    localparam logic [1:0] TRIG_ANY  = 2'd2;

    // Does this lookup outcome start autoload under the given trigger mode?
    function automatic logic trig_fires(input logic [1:0] mode, input logic hit);
        unique case (mode)
            TRIG_MISS: trig_fires = !hit;
            TRIG_HIT:  trig_fires = hit;
            TRIG_ANY:  trig_fires = 1'b1;
            default:   trig_fires = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/icpf_region_match.sv
module icpf_region_match #(
    parameter int AW = 32
) (
    input  logic          en,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] size,
    input  logic [AW-1:0] addr,
    output logic          hit,
    output logic [AW:0]   lo,
    output logic [AW:0]   hi
);
    // Wide bounds so base+size never wraps.
    assign lo  = {1'b0, base};
    assign hi  = {1'b0, base} + {1'b0, size};
    assign hit = en && ({1'b0, addr} >= lo) && ({1'b0, addr} < hi);
endmodule

// File: rtl/icpf_line_step.sv
module icpf_line_step #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic [AW-1:0] cur,
    input  logic          dir,
    input  logic [AW:0]   lo,
    input  logic [AW:0]   hi,
    output logic [AW-1:0] nxt,
    output logic          ok
);
    localparam logic [AW:0] STEP = (AW+1)'(LINE_BYTES);

    logic [AW:0] up_w, dn_w;

    assign up_w = {1'b0, cur} + STEP;
    assign dn_w = {1'b0, cur} - STEP;
    assign nxt  = dir ? dn_w[AW-1:0] : up_w[AW-1:0];
    assign ok   = dir ? (({1'b0, cur} >= STEP) && (dn_w >= lo)) : (up_w < hi);
endmodule

// File: rtl/icache_prefetch_engine.sv
module icache_prefetch_engine
    import icpf_pkg::*;
#(
    parameter int AW          = 32,
    parameter int LINE_BYTES  = 16,
    parameter int CACHE_BYTES = 16384,
    parameter int AUTO_LINES  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_order,
    input  logic [1:0]    cfg_trigger,
    input  logic          cfg_auto_we,
    input  logic          cfg_auto_wdata,
    input  logic          rgn0_en,
    input  logic [AW-1:0] rgn0_base,
    input  logic [AW-1:0] rgn0_size,
    input  logic          rgn1_en,
    input  logic [AW-1:0] rgn1_base,
    input  logic [AW-1:0] rgn1_size,
    input  logic          lookup_valid,
    input  logic          lookup_hit,
    input  logic [AW-1:0] lookup_addr,
    input  logic          freeze,
    input  logic          man_start,
    input  logic [AW-1:0] man_addr,
    input  logic [AW-1:0] man_size,
    input  logic          man_order,
    input  logic          man_end,
    output logic          man_done,
    output logic          man_prev_auto,
    output logic          auto_on,
    output logic          req_valid,
    input  logic          req_ready,
    output logic [AW-1:0] req_addr,
    input  logic          fill_done
);
    localparam int          NRGN     = 2;
    localparam int          LSB      = $clog2(LINE_BYTES);
    localparam int          CLINES   = CACHE_BYTES / LINE_BYTES;
    localparam int          CW       = $clog2(CLINES + 1);
    localparam logic [AW-1:0] LOW_MASK = AW'(LINE_BYTES - 1);
    localparam logic [AW:0] TOP      = {1'b1, {AW{1'b0}}};

    // ---------------- address windows ----------------
    logic [NRGN-1:0] rg_en, rg_hit;
    logic [AW-1:0]   rg_base [NRGN];
    logic [AW-1:0]   rg_size [NRGN];
    logic [AW:0]     rg_lo   [NRGN];
    logic [AW:0]     rg_hi   [NRGN];

    assign rg_en      = {rgn1_en, rgn0_en};
    assign rg_base[0] = rgn0_base;
    assign rg_base[1] = rgn1_base;
    assign rg_size[0] = rgn0_size;
    assign rg_size[1] = rgn1_size;

    genvar g;
    generate
        for (g = 0; g < NRGN; g++) begin : g_rgn
            icpf_region_match #(.AW(AW)) u_match (
                .en  (rg_en[g]),
                .base(rg_base[g]),
                .size(rg_size[g]),
                .addr(lookup_addr),
                .hit (rg_hit[g]),
                .lo  (rg_lo[g]),
                .hi  (rg_hi[g])
            );
        end
    endgenerate

    // ---------------- state ----------------
    pf_state_e     state, state_nx;
    logic [AW-1:0] cur;
    logic          cur_dir;
    logic [CW-1:0] cnt;
    logic [AW:0]   b_lo, b_hi;
    logic          auto_en, saved_en, man_pend, done_q;
    logic [AW-1:0] m_addr;
    logic          m_dir;
    logic [CW-1:0] m_cnt;

    // ---------------- shared stepper ----------------
    logic          idle;
    logic [AW-1:0] lk_line, st_in, st_nxt;
    logic [AW:0]   sel_lo, sel_hi, st_lo, st_hi, size_up, man_lines;
    logic          st_dir, st_ok;

    assign idle    = (state == PF_IDLE);
    assign lk_line = lookup_addr & ~LOW_MASK;
    assign sel_lo  = rg_hit[0] ? rg_lo[0] : rg_lo[1];
    assign sel_hi  = rg_hit[0] ? rg_hi[0] : rg_hi[1];
    assign st_in   = idle ? lk_line   : cur;
    assign st_dir  = idle ? cfg_order : cur_dir;
    assign st_lo   = idle ? sel_lo    : b_lo;
    assign st_hi   = idle ? sel_hi    : b_hi;

    icpf_line_step #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_step (
        .cur(st_in),
        .dir(st_dir),
        .lo (st_lo),
        .hi (st_hi),
        .nxt(st_nxt),
        .ok (st_ok)
    );

    // ---------------- qualifying events ----------------
    logic man_acc, auto_go, acc, more;

    assign man_acc   = man_start && done_q;
    assign auto_go   = lookup_valid && auto_en && !man_pend && !man_acc &&
                       trig_fires(cfg_trigger, lookup_hit) && (|rg_hit) && st_ok;
    assign acc       = req_valid && req_ready;
    assign more      = (cnt > CW'(1)) && st_ok;
    assign size_up   = {1'b0, man_size} + (AW+1)'(LINE_BYTES - 1);
    assign man_lines = size_up >> LSB;

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            PF_IDLE: begin
                if (man_pend)
                    state_nx = (m_cnt == '0) ? PF_IDLE : PF_MAN_REQ;
                else if (auto_go)
                    state_nx = PF_AUTO_REQ;
            end
            PF_AUTO_REQ:  if (acc) state_nx = PF_AUTO_WAIT;
            PF_AUTO_WAIT: if (fill_done) state_nx = (more && auto_en) ? PF_AUTO_REQ : PF_IDLE;
            PF_MAN_REQ:   if (acc) state_nx = PF_MAN_WAIT;
            PF_MAN_WAIT:  if (fill_done) state_nx = more ? PF_MAN_REQ : PF_IDLE;
            default:      state_nx = PF_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PF_IDLE;
        else        state <= state_nx;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur      <= '0;
            cur_dir  <= 1'b0;
            cnt      <= '0;
            b_lo     <= '0;
            b_hi     <= '0;
            auto_en  <= 1'b0;
            saved_en <= 1'b0;
            man_pend <= 1'b0;
            done_q   <= 1'b1;
            m_addr   <= '0;
            m_dir    <= 1'b0;
            m_cnt    <= '0;
        end else begin
            if (idle && man_pend) begin
                cur      <= m_addr;
                cur_dir  <= m_dir;
                cnt      <= m_cnt;
                b_lo     <= '0;
                b_hi     <= TOP;
                man_pend <= 1'b0;
                if (m_cnt == '0) done_q <= 1'b1;
            end else if (idle && auto_go) begin
                cur     <= st_nxt;
                cur_dir <= cfg_order;
                cnt     <= CW'(AUTO_LINES);
                b_lo    <= sel_lo;
                b_hi    <= sel_hi;
            end
            if ((state == PF_AUTO_WAIT || state == PF_MAN_WAIT) && fill_done) begin
                cnt <= cnt - CW'(1);
                cur <= st_nxt;
                if (state == PF_MAN_WAIT && !more) done_q <= 1'b1;
            end
            if (cfg_auto_we) auto_en <= cfg_auto_wdata;
            if (man_end)     auto_en <= saved_en;
            if (man_acc) begin
                saved_en <= auto_en;
                auto_en  <= 1'b0;
                man_pend <= 1'b1;
                done_q   <= 1'b0;
                m_addr   <= man_addr & ~LOW_MASK;
                m_dir    <= man_order;
                m_cnt    <= (man_lines > (AW+1)'(CLINES)) ? CW'(CLINES) : CW'(man_lines);
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        req_valid     = (state == PF_AUTO_REQ || state == PF_MAN_REQ) && !freeze;
        req_addr      = cur;
        man_done      = done_q;
        man_prev_auto = saved_en;
        auto_on       = auto_en;
    end

endmodule

// File: rtl/icpf_checker.sv
module icpf_checker #(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          freeze,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          fill_done,
    input logic          man_start,
    input logic          man_done,
    input logic          auto_on
);
    localparam logic [AW-1:0] LOW_MASK = AW'(LINE_BYTES - 1);

    logic in_flight;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      in_flight <= 1'b0;
        else if (req_valid && req_ready) in_flight <= 1'b1;
        else if (fill_done)              in_flight <= 1'b0;
    end

    // R10
    frz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |-> !req_valid);

    // R1
    line_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_addr & LOW_MASK) == '0));

    // R1
    single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_flight |-> !req_valid);

    // R1
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> $stable(req_addr));

    // R6
    man_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (man_start && man_done) |=> (!auto_on && !man_done));
endmodule

bind icache_prefetch_engine icpf_checker #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_icpf_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze   (freeze),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr (req_addr),
    .fill_done(fill_done),
    .man_start(man_start),
    .man_done (man_done),
    .auto_on  (auto_on)
);

// File: tb/icache_prefetch_engine_tb_top.sv
`timescale 1ns/1ps
module icache_prefetch_engine_tb_top;
    localparam int AW = 32;
    localparam int LB = 16;
    localparam int CB = 16384;
    localparam int AL = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          cfg_order = 0, cfg_auto_we = 0, cfg_auto_wdata = 0;
    logic [1:0]    cfg_trigger = 0;
    logic          rgn0_en = 0, rgn1_en = 0;
    logic [AW-1:0] rgn0_base = 0, rgn0_size = 0, rgn1_base = 0, rgn1_size = 0;
    logic          lookup_valid = 0, lookup_hit = 0;
    logic [AW-1:0] lookup_addr = 0;
    logic          freeze = 0, man_start = 0, man_order = 0, man_end = 0;
    logic [AW-1:0] man_addr = 0, man_size = 0;
    logic          man_done, man_prev_auto, auto_on, req_valid;
    logic          req_ready = 0, fill_done = 0;
    logic [AW-1:0] req_addr;

    icache_prefetch_engine #(.AW(AW), .LINE_BYTES(LB), .CACHE_BYTES(CB), .AUTO_LINES(AL)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_order(cfg_order), .cfg_trigger(cfg_trigger),
        .cfg_auto_we(cfg_auto_we), .cfg_auto_wdata(cfg_auto_wdata),
        .rgn0_en(rgn0_en), .rgn0_base(rgn0_base), .rgn0_size(rgn0_size),
        .rgn1_en(rgn1_en), .rgn1_base(rgn1_base), .rgn1_size(rgn1_size),
        .lookup_valid(lookup_valid), .lookup_hit(lookup_hit), .lookup_addr(lookup_addr),
        .freeze(freeze), .man_start(man_start), .man_addr(man_addr), .man_size(man_size),
        .man_order(man_order), .man_end(man_end), .man_done(man_done),
        .man_prev_auto(man_prev_auto), .auto_on(auto_on), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .fill_done(fill_done)
    );

    int total = 0, bad = 0, viol = 0;
    bit exp_auto = 0;
    logic [AW-1:0] got[$];
    logic [AW-1:0] exp_q[$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic report();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Fill-side model: accept each request, then pulse fill_done.
    task automatic responder();
        forever begin
            @(negedge clk);
            if (req_valid) begin
                got.push_back(req_addr);
                req_ready = 1;
                @(negedge clk);
                req_ready = 0;
                for (int k = 0; k < 3; k++) begin
                    if (req_valid) viol++;
                    @(negedge clk);
                end
                fill_done = 1;
                @(negedge clk);
                fill_done = 0;
            end
        end
    endtask

    function automatic void model_auto(input logic [AW-1:0] a, input bit h);
        longint lo, hi, c, nx;
        bit fire;
        fire = (cfg_trigger == 0 && !h) || (cfg_trigger == 1 && h) || (cfg_trigger == 2);
        if (!exp_auto || !fire) return;
        if (rgn0_en && a >= rgn0_base && longint'(a) < longint'(rgn0_base) + longint'(rgn0_size)) begin
            lo = rgn0_base; hi = longint'(rgn0_base) + longint'(rgn0_size);
        end else if (rgn1_en && a >= rgn1_base && longint'(a) < longint'(rgn1_base) + longint'(rgn1_size)) begin
            lo = rgn1_base; hi = longint'(rgn1_base) + longint'(rgn1_size);
        end else return;
        c = a & ~(LB - 1);
        for (int i = 0; i < AL; i++) begin
            if (!cfg_order) begin
                nx = c + LB;
                if (nx >= hi) break;
            end else begin
                if (c < LB) break;
                nx = c - LB;
                if (nx < lo) break;
            end
            exp_q.push_back(nx[AW-1:0]);
            c = nx;
        end
    endfunction

    function automatic void model_man(input logic [AW-1:0] a, input logic [AW-1:0] sz, input bit ord);
        longint c, n;
        c = a & ~(LB - 1);
        n = (longint'(sz) + LB - 1) / LB;
        if (n > CB / LB) n = CB / LB;
        for (longint i = 0; i < n; i++) begin
            exp_q.push_back(c[AW-1:0]);
            if (!ord) begin
                if (c + LB >= 64'h1_0000_0000) break;
                c = c + LB;
            end else begin
                if (c < LB) break;
                c = c - LB;
            end
        end
    endfunction

    task automatic cmp_seq(input string tag);
        bit ok = (got.size() == exp_q.size());
        int first = -1;
        if (ok) foreach (exp_q[i]) if (got[i] !== exp_q[i] && first < 0) begin ok = 0; first = i; end
        if (ok) chk(1, tag, 0, 0);
        else if (first < 0) chk(0, {tag, " line count"}, got.size(), exp_q.size());
        else chk(0, {tag, " line address"}, got[first], exp_q[first]);
        got.delete();
        exp_q.delete();
    endtask

    task automatic set_auto(input bit v);
        @(negedge clk);
        cfg_auto_we = 1; cfg_auto_wdata = v;
        @(negedge clk);
        cfg_auto_we = 0;
        exp_auto = v;
    endtask

    task automatic lookup(input logic [AW-1:0] a, input bit h);
        @(negedge clk);
        lookup_valid = 1; lookup_addr = a; lookup_hit = h;
        @(negedge clk);
        lookup_valid = 0;
    endtask

    task automatic auto_case(input logic [AW-1:0] a, input bit h, input string tag);
        model_auto(a, h);
        lookup(a, h);
        repeat (40) @(negedge clk);
        cmp_seq(tag);
    endtask

    task automatic pulse_end();
        @(negedge clk);
        man_end = 1;
        @(negedge clk);
        man_end = 0;
        exp_auto = man_prev_auto;
    endtask

    task automatic wait_man();
        int n = 0;
        while (!man_done && n < 30000) begin @(negedge clk); n++; end
        repeat (10) @(negedge clk);
    endtask

    // Start pulse; return with the bench at the negedge after the accepting edge.
    task automatic start_man(input logic [AW-1:0] a, input logic [AW-1:0] sz, input bit ord);
        @(negedge clk);
        man_start = 1; man_addr = a; man_size = sz; man_order = ord;
        @(negedge clk);
        man_start = 0;
    endtask

    initial begin
        for (int c = 0; c < 190000; c++) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        report();
    end

    initial begin
        bit pa;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(req_valid == 0 && man_done == 1 && auto_on == 0 && man_prev_auto == 0,
            "R12 reset outputs", {req_valid, man_done, auto_on, man_prev_auto}, 4'b0100);
        rst_n = 1;
        fork responder(); join_none

        rgn0_en = 1; rgn0_base = 32'h1000; rgn0_size = 32'h100;
        rgn1_en = 0; rgn1_base = 32'h0; rgn1_size = 32'h40;
        cfg_trigger = 0; cfg_order = 0;

        auto_case(32'h1004, 0, "R2 enable off, no lines");
        set_auto(1);
        chk(auto_on == 1, "R2 enable written", auto_on, 1);
        auto_case(32'h1004, 0, "R4 up miss");
        auto_case(32'h1004, 1, "R2 miss mode ignores hit");
        cfg_trigger = 1;
        auto_case(32'h1024, 1, "R2 hit mode hit");
        auto_case(32'h1024, 0, "R2 hit mode ignores miss");
        cfg_trigger = 2;
        auto_case(32'h1044, 0, "R2 both mode miss");
        auto_case(32'h1044, 1, "R2 both mode hit");
        cfg_trigger = 3;
        auto_case(32'h1044, 0, "R2 mode 3 none");
        cfg_trigger = 0;
        cfg_order = 1;
        auto_case(32'h1084, 0, "R4 down");
        auto_case(32'h1010, 0, "R5 down stops at base");
        cfg_order = 0;
        auto_case(32'h10F0, 0, "R5 up at last line");
        auto_case(32'h10E8, 0, "R5 up one line left");
        auto_case(32'h2000, 0, "R3 outside window");
        rgn1_en = 1; cfg_order = 1;
        auto_case(32'h0008, 0, "R5 no wrap below zero");
        cfg_order = 0;
        auto_case(32'h0010, 0, "R3 window 1");
        rgn1_base = 32'h1000; rgn1_size = 32'h200;
        auto_case(32'h10F0, 0, "R3 window 0 precedence");
        rgn0_en = 0;
        auto_case(32'h10F0, 0, "R3 window 0 disabled");
        rgn0_en = 1; rgn1_base = 32'h0; rgn1_size = 32'h40;

        // R6 R7 R8 R9 manual preload
        model_man(32'h2004, 32'h30, 0);
        start_man(32'h2004, 32'h30, 0);
        chk(man_done == 0, "R8 done low after start", man_done, 0);
        chk(auto_on == 0 && man_prev_auto == 1, "R6 suspend and saved enable",
            {auto_on, man_prev_auto}, 2'b01);
        exp_auto = 0;
        wait_man();
        chk(man_done == 1, "R8 done high at end", man_done, 1);
        cmp_seq("R7 manual up");
        chk(auto_on == 0, "R6 still suspended", auto_on, 0);
        pulse_end();
        chk(auto_on == 1, "R9 enable restored", auto_on, 1);

        model_man(32'h0010, 32'h40, 1);
        start_man(32'h0010, 32'h40, 1);
        wait_man();
        cmp_seq("R7 manual down stops at zero");
        pulse_end();

        model_man(32'hFFFF_FFE0, 32'h100, 0);
        start_man(32'hFFFF_FFE0, 32'h100, 0);
        wait_man();
        cmp_seq("R7 manual up stops at top");
        pulse_end();

        start_man(32'h3000, 32'h0, 0);
        chk(man_done == 0, "R8 zero size low", man_done, 0);
        @(negedge clk);
        chk(man_done == 1, "R8 zero size done", man_done, 1);
        repeat (10) @(negedge clk);
        cmp_seq("R8 zero size no lines");
        pulse_end();

        model_man(32'h8000, 32'h10000, 0);
        start_man(32'h8000, 32'h10000, 0);
        wait_man();
        cmp_seq("R7 size clamped to capacity");
        pulse_end();

        // R11 lookups and second start ignored while manual runs
        model_man(32'h1000, 32'h80, 0);
        start_man(32'h1000, 32'h80, 0);
        repeat (6) @(negedge clk);
        pulse_end();
        lookup(32'h1004, 0);
        start_man(32'h5000, 32'h40, 0);
        wait_man();
        cmp_seq("R11 busy ignores lookup and start");
        chk(auto_on == 1, "R9 restored during run", auto_on, 1);

        // R10 freeze over a pending request
        freeze = 1;
        model_auto(32'h1004, 0);
        lookup(32'h1004, 0);
        begin
            bit seen = 0;
            for (int k = 0; k < 20; k++) begin @(negedge clk); if (req_valid) seen = 1; end
            chk(!seen, "R10 no request while frozen", seen, 0);
        end
        freeze = 0;
        repeat (40) @(negedge clk);
        cmp_seq("R10 request after thaw");

        // R6 collision: start and qualifying lookup in the same cycle
        @(negedge clk);
        model_man(32'h4000, 32'h20, 0);
        man_start = 1; man_addr = 32'h4000; man_size = 32'h20; man_order = 0;
        lookup_valid = 1; lookup_addr = 32'h1004; lookup_hit = 0;
        @(negedge clk);
        man_start = 0; lookup_valid = 0;
        pa = man_prev_auto;
        chk(pa == 1 && auto_on == 0, "R6 collision saved enable", {pa, auto_on}, 2'b10);
        wait_man();
        cmp_seq("R6 collision manual only");
        pulse_end();

        // Random autoload trials
        for (int t = 0; t < 60; t++) begin
            logic [AW-1:0] a;
            rgn0_en = $urandom_range(0, 3) != 0;
            rgn1_en = $urandom_range(0, 1);
            rgn0_base = 32'h1000 + $urandom_range(0, 32'h3FF);
            rgn0_size = $urandom_range(1, 32'h300);
            rgn1_base = 32'h1200 + $urandom_range(0, 32'h3FF);
            rgn1_size = $urandom_range(1, 32'h300);
            cfg_trigger = 2'($urandom_range(0, 3));
            cfg_order = $urandom_range(0, 1);
            if ($urandom_range(0, 7) == 0) set_auto(!exp_auto);
            a = 32'h0FE0 + $urandom_range(0, 32'h800);
            auto_case(a, $urandom_range(0, 1), "R4 R5 random autoload");
        end
        if (!exp_auto) set_auto(1);

        chk(viol == 0, "R1 one request outstanding", viol, 0);
        report();
    end
endmodule